// File: doc/BRIEF.md
# Keyed Multi-Function I/O Configuration Register File

This block holds the setup registers of a multi-function I/O chip behind a byte-wide host port with two addresses. The low address is the index port and the high address (index address + 1) is the data port. The index byte picks the register that the data port reaches. Every register stays closed to the host until a key byte is written to the index port. A second key byte closes them again.

A select register chooses one of eight logical device banks. Each bank holds an activate byte, a 16-bit I/O base, two IRQ numbers, a DMA channel and two option bytes. The contents of every bank drive dedicated output buses. Downstream logic uses these buses to enable and place the floppy, parallel, serial and keyboard functions. A fixed identification byte can be read so that software can confirm the chip before it programs anything. Reads are combinational: `host_rdata` reflects the addressed register in the same cycle.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked, every bank is cleared, `dev_active` is all zero, and both ports read 0x00.
- R2: Writing 0x55 to the index port (`host_sel`=0) while locked opens configuration mode without changing the index. Any other index byte written while locked is ignored.
- R3: Writing 0xAA to the index port while open locks the port and leaves the index unchanged. While locked, both ports read 0x00.
- R4: Writes to the data port (`host_sel`=1) while locked change no register and no output.
- R5: While open, an index-port write other than 0xAA stores the byte as the current index. A read of the index port returns that index.
- R6: Index 0x20 reads 0x40 through the data port. Writes to it have no effect.
- R7: Index 0x07 is the bank select. It keeps the low three bits of the written byte, reads back with the upper bits zero, and picks the bank that indices 0x30 to 0xFF address.
- R8: Index 0x30 of a bank reads back the whole byte written. Bit 0 of that byte drives `dev_active[bank]`.
- R9: Index 0x60 is the high byte and index 0x61 is the low byte of `dev_base[bank]`. Both read back.
- R10: Indices 0x70, 0x72 and 0x74 drive `dev_irq_a`, `dev_irq_b` and `dev_dma`. Indices 0xF0 and 0xF1 drive `dev_opt_a` and `dev_opt_b`. All of them read back.
- R11: Any other index reads 0x00, and data writes to it change nothing.
- R12: A write to one bank leaves every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte of the selected port (combinational) |
| dev_active | output | NDEV | Activate flag of each bank |
| dev_base | output | NDEV x 16 | I/O base address of each bank |
| dev_irq_a | output | NDEV x 8 | Primary IRQ number of each bank |
| dev_irq_b | output | NDEV x 8 | Secondary IRQ number of each bank |
| dev_dma | output | NDEV x 8 | DMA channel of each bank |
| dev_opt_a | output | NDEV x 8 | First option byte of each bank |
| dev_opt_b | output | NDEV x 8 | Second option byte of each bank |

## Verification
The case that is hardest to reach from the ports is a locked port that still holds a live index which points at a real register. That state shows whether locked data writes and stray index bytes are truly discarded. The stimulus opens the port, points the index at the activate byte of a chosen bank, and then closes the port. It next fires a data write and a stray index byte, reopens the port and reads the index port. The read must return the old index, and `dev_active` must be unchanged until a data write is made while the port is open.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    localparam logic [7:0] KEY_OPEN   = 8'h55;
    localparam logic [7:0] KEY_CLOSE  = 8'hAA;
    localparam logic [7:0] IDX_BANK   = 8'h07;
    localparam logic [7:0] IDX_IDENT  = 8'h20;
    localparam logic [7:0] IDENT_BYTE = 8'h40;

    typedef enum logic [3:0] {
        FLD_ACT, FLD_BASE_HI, FLD_BASE_LO, FLD_IRQ_A, FLD_IRQ_B,
        FLD_DMA, FLD_OPT_A, FLD_OPT_B, FLD_NONE
    } fld_e;

    typedef struct packed {
        logic [7:0] act;
        logic [7:0] base_hi;
        logic [7:0] base_lo;
        logic [7:0] irq_a;
        logic [7:0] irq_b;
        logic [7:0] dma;
        logic [7:0] opt_a;
        logic [7:0] opt_b;
    } bank_t;

    typedef enum logic {ST_LOCKED, ST_OPEN} key_st_e;

    function automatic fld_e idx_to_fld(input logic [7:0] idx);
        case (idx)
            8'h30:   return FLD_ACT;
            8'h60:   return FLD_BASE_HI;
            8'h61:   return FLD_BASE_LO;
            8'h70:   return FLD_IRQ_A;
            8'h72:   return FLD_IRQ_B;
            8'h74:   return FLD_DMA;
            8'hF0:   return FLD_OPT_A;
            8'hF1:   return FLD_OPT_B;
            default: return FLD_NONE;
        endcase
    endfunction

    function automatic logic [7:0] pick_fld(input bank_t b, input fld_e f);
        case (f)
            FLD_ACT:     return b.act;
            FLD_BASE_HI: return b.base_hi;
            FLD_BASE_LO: return b.base_lo;
            FLD_IRQ_A:   return b.irq_a;
            FLD_IRQ_B:   return b.irq_b;
            FLD_DMA:     return b.dma;
            FLD_OPT_A:   return b.opt_a;
            FLD_OPT_B:   return b.opt_b;
            default:     return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/sio_key_ctl.sv
module sio_key_ctl
    import sio_cfg_pkg::*;
#(
    parameter int LDN_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             sel,
    input  logic [7:0]       wdata,
    output logic             cfg_open,
    output logic [7:0]       cur_idx,
    output logic [LDN_W-1:0] ldn,
    output logic             data_we
);
    key_st_e st;

    assign cfg_open = (st == ST_OPEN);
    assign data_we  = wr && sel && cfg_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_LOCKED;
            cur_idx <= 8'h00;
            ldn     <= '0;
        end else begin
            if (wr && !sel) begin
                if (st == ST_LOCKED) begin
                    if (wdata == KEY_OPEN)
                        st <= ST_OPEN;
                end else if (wdata == KEY_CLOSE) begin
                    st <= ST_LOCKED;
                end else begin
                    cur_idx <= wdata;
                end
            end
            if (data_we && cur_idx == IDX_BANK)
                ldn <= wdata[LDN_W-1:0];
        end
    end

endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  fld_e       fld,
    input  logic [7:0] wdata,
    output bank_t      regs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (wr_en) begin
            case (fld)
                FLD_ACT:     regs.act     <= wdata;
                FLD_BASE_HI: regs.base_hi <= wdata;
                FLD_BASE_LO: regs.base_lo <= wdata;
                FLD_IRQ_A:   regs.irq_a   <= wdata;
                FLD_IRQ_B:   regs.irq_b   <= wdata;
                FLD_DMA:     regs.dma     <= wdata;
                FLD_OPT_A:   regs.opt_a   <= wdata;
                FLD_OPT_B:   regs.opt_b   <= wdata;
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int NDEV = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_wr,
    input  logic                 host_sel,
    input  logic [7:0]           host_wdata,
    output logic [7:0]           host_rdata,
    output logic [NDEV-1:0]      dev_active,
    output logic [NDEV-1:0][15:0] dev_base,
    output logic [NDEV-1:0][7:0] dev_irq_a,
    output logic [NDEV-1:0][7:0] dev_irq_b,
    output logic [NDEV-1:0][7:0] dev_dma,
    output logic [NDEV-1:0][7:0] dev_opt_a,
    output logic [NDEV-1:0][7:0] dev_opt_b
);
    localparam int LDN_W = (NDEV > 1) ? $clog2(NDEV) : 1;

    logic             cfg_open;
    logic [7:0]       cur_idx;
    logic [LDN_W-1:0] ldn;
    logic             data_we;
    fld_e             fld;
    bank_t            banks [NDEV];
    bank_t            sel_bank;

    sio_key_ctl #(.LDN_W(LDN_W)) u_key (
        .clk      (clk),
        .rst      (rst),
        .wr       (host_wr),
        .sel      (host_sel),
        .wdata    (host_wdata),
        .cfg_open (cfg_open),
        .cur_idx  (cur_idx),
        .ldn      (ldn),
        .data_we  (data_we)
    );

    assign fld = idx_to_fld(cur_idx);

    for (genvar g = 0; g < NDEV; g++) begin : g_bank
        sio_dev_bank u_bank (
            .clk   (clk),
            .rst   (rst),
            .wr_en (data_we && (ldn == LDN_W'(g)) && (fld != FLD_NONE)),
            .fld   (fld),
            .wdata (host_wdata),
            .regs  (banks[g])
        );
        assign dev_active[g] = banks[g].act[0];
        assign dev_base[g]   = {banks[g].base_hi, banks[g].base_lo};
        assign dev_irq_a[g]  = banks[g].irq_a;
        assign dev_irq_b[g]  = banks[g].irq_b;
        assign dev_dma[g]    = banks[g].dma;
        assign dev_opt_a[g]  = banks[g].opt_a;
        assign dev_opt_b[g]  = banks[g].opt_b;
    end

    always_comb begin
        sel_bank = '0;
        for (int i = 0; i < NDEV; i++)
            if (ldn == LDN_W'(i))
                sel_bank = banks[i];
    end

    always_comb begin
        host_rdata = 8'h00;
        if (cfg_open) begin
            if (!host_sel)
                host_rdata = cur_idx;
            else if (cur_idx == IDX_IDENT)
                host_rdata = IDENT_BYTE;
            else if (cur_idx == IDX_BANK)
                host_rdata = 8'(ldn);
            else
                host_rdata = pick_fld(sel_bank, fld);
        end
    end

endmodule

// File: rtl/sio_cfg_chk.sv
module sio_cfg_chk #(
    parameter int NDEV = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  host_wr,
    input logic                  host_sel,
    input logic [7:0]            host_wdata,
    input logic [7:0]            host_rdata,
    input logic                  cfg_open,
    input logic [7:0]            cur_idx,
    input logic [NDEV-1:0]       dev_active,
    input logic [NDEV-1:0][15:0] dev_base
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!cfg_open && dev_active == '0 && dev_base == '0));

    // R2
    unlock_key_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_open && host_wr && !host_sel && host_wdata == 8'h55) |=> cfg_open);

    // R2
    stray_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_open && host_wr && !host_sel && host_wdata != 8'h55) |=> (!cfg_open && $stable(cur_idx)));

    // R3
    lock_key_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_open && host_wr && !host_sel && host_wdata == 8'hAA) |=> (!cfg_open && $stable(cur_idx)));

    // R3
    locked_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_open |-> host_rdata == 8'h00);

    // R4
    locked_data_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_open && host_wr && host_sel) |=> ($stable(dev_active) && $stable(dev_base)));

    // R6
    ident_read_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_open && host_sel && cur_idx == 8'h20) |-> host_rdata == 8'h40);

    // R5
    index_read_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_open && !host_sel) |-> host_rdata == cur_idx);

endmodule

bind sio_cfg_port sio_cfg_chk #(.NDEV(NDEV)) u_chk (.*);

// File: tb/sim_sio_cfg_port.sv
`timescale 1ns/1ps
module sim_sio_cfg_port;
    localparam int NDEV = 8;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  host_wr = 1'b0;
    logic                  host_sel = 1'b0;
    logic [7:0]            host_wdata = 8'h00;
    logic [7:0]            host_rdata;
    logic [NDEV-1:0]       dev_active;
    logic [NDEV-1:0][15:0] dev_base;
    logic [NDEV-1:0][7:0]  dev_irq_a, dev_irq_b, dev_dma, dev_opt_a, dev_opt_b;

    int total = 0;
    int bad   = 0;

    sio_cfg_port #(.NDEV(NDEV)) u0 (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dev_active(dev_active), .dev_base(dev_base),
        .dev_irq_a(dev_irq_a), .dev_irq_b(dev_irq_b), .dev_dma(dev_dma),
        .dev_opt_a(dev_opt_a), .dev_opt_b(dev_opt_b)
    );

    always #5 clk = ~clk;

    // {read, sel, byte}: a write sends byte, a read expects byte
    localparam int NV = 45;
    localparam logic [9:0] VEC [0:NV-1] = '{
        {2'b00, 8'h55},
        {2'b00, 8'h07}, {2'b01, 8'h03}, {2'b11, 8'h03},
        {2'b00, 8'h60}, {2'b01, 8'h03}, {2'b00, 8'h61}, {2'b01, 8'h78},
        {2'b00, 8'h70}, {2'b01, 8'h07}, {2'b00, 8'hF1}, {2'b01, 8'h02},
        {2'b00, 8'h30}, {2'b01, 8'h01},
        {2'b00, 8'h07}, {2'b01, 8'h04},
        {2'b00, 8'h60}, {2'b01, 8'h03}, {2'b00, 8'h61}, {2'b01, 8'hF8},
        {2'b00, 8'h70}, {2'b01, 8'h04}, {2'b00, 8'h30}, {2'b01, 8'h01},
        {2'b00, 8'h07}, {2'b01, 8'h03},
        {2'b00, 8'h61}, {2'b11, 8'h78}, {2'b00, 8'h60}, {2'b11, 8'h03},
        {2'b00, 8'h70}, {2'b11, 8'h07}, {2'b00, 8'hF1}, {2'b11, 8'h02},
        {2'b00, 8'h72}, {2'b11, 8'h00}, {2'b00, 8'h30}, {2'b11, 8'h01},
        {2'b00, 8'h07}, {2'b01, 8'h04},
        {2'b00, 8'h61}, {2'b11, 8'hF8}, {2'b00, 8'h70}, {2'b11, 8'h04},
        {2'b00, 8'h74}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, input logic [7:0] exp, input string req);
        @(negedge clk);
        host_wr = 1'b0; host_sel = sel;
        #1;
        check(req, {24'h0, host_rdata}, {24'h0, exp});
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 active", 32'(dev_active), 32'h0);
        check("R1 base", 32'(dev_base[3]), 32'h0);
        rd(1'b1, 8'h00, "R1 data read");
        rd(1'b0, 8'h00, "R1 index read");

        // R9/R10/R12 vector walk over two banks
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][9]) rd(VEC[i][8], VEC[i][7:0], "R9/R10/R12 vector");
            else           wr(VEC[i][8], VEC[i][7:0]);
        end
        rd(1'b1, 8'h00, "R10 dma bank4");
        check("R8 active", 32'(dev_active), 32'h18);
        check("R9 base3", 32'(dev_base[3]), 32'h0378);
        check("R12 base4", 32'(dev_base[4]), 32'h03F8);
        check("R10 irq3", 32'(dev_irq_a[3]), 32'h07);
        check("R10 opt3", 32'(dev_opt_b[3]), 32'h02);
        check("R12 opt4", 32'(dev_opt_b[4]), 32'h00);

        // R6: identification byte, writes ignored
        wr(1'b0, 8'h20); rd(1'b1, 8'h40, "R6 ident");
        wr(1'b1, 8'h11); rd(1'b1, 8'h40, "R6 ident after write");

        // R7: bank select keeps low bits
        wr(1'b0, 8'h07); wr(1'b1, 8'hFD); rd(1'b1, 8'h05, "R7 bank readback");

        // R11: unimplemented index
        wr(1'b0, 8'h31); wr(1'b1, 8'h5A); rd(1'b1, 8'h00, "R11 read zero");
        check("R11 outputs", 32'(dev_active), 32'h18);
        rd(1'b0, 8'h31, "R5 index read");

        // R3 / R4 / R2: lock with live index at activate byte of bank 5
        wr(1'b0, 8'h30);
        wr(1'b0, 8'hAA);
        rd(1'b0, 8'h00, "R3 index locked");
        rd(1'b1, 8'h00, "R3 data locked");
        wr(1'b1, 8'h01);
        check("R4 locked write", 32'(dev_active), 32'h18);
        wr(1'b0, 8'h12);
        wr(1'b0, 8'h55);
        rd(1'b0, 8'h30, "R2 index kept");
        rd(1'b1, 8'h00, "R4 bank5 unchanged");

        // R8: whole byte read back, bit 0 drives active
        wr(1'b1, 8'h03);
        check("R8 active5", 32'(dev_active), 32'h38);
        rd(1'b1, 8'h03, "R8 readback");

        // R1: reset again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 active after reset", 32'(dev_active), 32'h0);
        rd(1'b1, 8'h00, "R1 locked after reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule